// File: doc/BRIEF.md
# Memory Request Pairing Arbiter

This block sits between the pipeline stages of a small 12-bit accumulator processor and a data cache that has two ports. In any cycle up to two memory requests arrive, one per slot. Each request carries a valid bit, a load/store kind, a 12-bit address, a wrapping age tag and a flag that marks a store needing a cache eviction. The arbiter decides whether the two requests may issue together. When they may not, the older slot issues and the younger slot is held for one cycle so that it can be presented again.

Slot 0 always stands ahead of slot 1 in position. Two loads always pair. Two stores pair only when their addresses differ and at most one of them needs an eviction. A load and a store pair only when the store is younger than the load by age tag. Age tags wrap: the candidate is younger when the difference (candidate minus base, modulo 2^AGE_W) is nonzero and its top bit is clear.

A separate miss controller holds the entire pipeline from a miss-start pulse until a fill-done pulse. While that hold is active nothing is granted, which keeps the ordering rules simple.

Top module: `mem_pair_arbiter`

## Requirements
- R1: After reset `missStall` is 0 and the arbiter grants requests normally.
- R2: Two valid loads are both granted in the same cycle, whatever their addresses or eviction flags.
- R3: Two valid stores are both granted when their addresses differ. With equal addresses the pair is illegal.
- R4: A load and a store (in either slot) are both granted only when the store's age tag is younger than the load's. Here younger means (storeAge - loadAge) mod 2^AGE_W is nonzero with a clear top bit. Otherwise the pair is illegal.
- R5: Two valid stores that both have the eviction flag set form an illegal pair. One eviction flag alone does not block pairing.
- R6: For an illegal pair, `grant0`=1, `grant1`=0 and `stall1`=1 in the same cycle.
- R7: A lone valid request in either slot is granted, and `stall1` stays 0.
- R8: `missStall` rises on the clock edge that samples `missStart`=1 and falls on the edge that samples `fillDone`=1. A `fillDone` while not stalled, or a `missStart` while stalled, has no effect.
- R9: While `missStall` is 1, `grant0`, `grant1` and `stall1` are all 0.
- R10: With no valid request, both grants and `stall1` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| s0Valid | input | 1 | Slot 0 request present |
| s0Store | input | 1 | Slot 0 kind: 0 load, 1 store |
| s0Evict | input | 1 | Slot 0 store needs a cache eviction |
| s0Addr | input | ADDR_W (12) | Slot 0 word address |
| s0Age | input | AGE_W (3) | Slot 0 wrapping age tag |
| s1Valid | input | 1 | Slot 1 request present |
| s1Store | input | 1 | Slot 1 kind: 0 load, 1 store |
| s1Evict | input | 1 | Slot 1 store needs a cache eviction |
| s1Addr | input | ADDR_W (12) | Slot 1 word address |
| s1Age | input | AGE_W (3) | Slot 1 wrapping age tag |
| missStart | input | 1 | Pulse: a cache miss has begun |
| fillDone | input | 1 | Pulse: the outstanding fill has completed |
| grant0 | output | 1 | Slot 0 request issues this cycle |
| grant1 | output | 1 | Slot 1 request issues this cycle |
| stall1 | output | 1 | Slot 1 held one cycle because of an illegal pair |
| missStall | output | 1 | Whole pipeline held for an outstanding miss |

## Verification
The bench covers each pairing class at its boundary. These include equal-address stores and double-eviction stores versus single-eviction stores. A design that compared addresses for loads, or checked eviction flags on any kind, would wrongly serialize loads. Mixed pairs are driven with equal age tags, with tags that wrap past zero, and with tags half the range apart. A signed or non-wrapping age compare would then pair a store with a load it must follow, or would split a legal pair. Miss handling is exercised by the following: an early fill-done, a second miss-start during the hold, and an illegal pair presented during the hold. A design that leaked grants or `stall1` through the hold, or re-armed on a repeated start, would be caught.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

  localparam int NUM_SLOTS = 2;

  typedef enum logic {
    REQ_LOAD  = 1'b0,
    REQ_STORE = 1'b1
  } reqKind_e;

  typedef enum logic {
    MISS_IDLE = 1'b0,
    MISS_HOLD = 1'b1
  } missState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic holdAll;
  } ctrlStrobes_t;

endpackage

// File: rtl/mpa_ctrl.sv
module mpa_ctrl
  import mpa_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         missStart,
  input  logic         fillDone,
  output ctrlStrobes_t strobes,
  output logic         missStall
);

  missState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      MISS_IDLE: if (missStart) stateNext = MISS_HOLD;
      MISS_HOLD: if (fillDone)  stateNext = MISS_IDLE;
      default:   stateNext = MISS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= MISS_IDLE;
    else       state <= stateNext;
  end

  assign missStall       = (state == MISS_HOLD);
  assign strobes.holdAll = missStall;

  // R8: a start seen while idle raises the hold
  a_r8_miss_enter: assert property (@(posedge clk) disable iff (!rstN)
    (!missStall && missStart) |=> missStall);
  // R8: the hold persists until a fill is seen
  a_r8_miss_hold: assert property (@(posedge clk) disable iff (!rstN)
    (missStall && !fillDone) |=> missStall);
  // R8: an idle fill pulse does nothing
  a_r8_idle_fill: assert property (@(posedge clk) disable iff (!rstN)
    (!missStall && !missStart) |=> !missStall);

endmodule

// File: rtl/mpa_datapath.sv
module mpa_datapath
  import mpa_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AGE_W  = 3
)(
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrobes_t                        strobes,
  input  logic [NUM_SLOTS-1:0]                valid,
  input  logic [NUM_SLOTS-1:0]                kind,
  input  logic [NUM_SLOTS-1:0]                evict,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]    addr,
  input  logic [NUM_SLOTS-1:0][AGE_W-1:0]     age,
  output logic [NUM_SLOTS-1:0]                grant,
  output logic                                stallLate
);

  localparam int AGE_MSB = AGE_W - 1;

  logic [NUM_SLOTS-1:0] isLd, isSt, stEv;
  logic addrMatch, pairLegal, bothValid;

  // per-slot kind decode
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign isLd[i] = valid[i] && (reqKind_e'(kind[i]) == REQ_LOAD);
    assign isSt[i] = valid[i] && (reqKind_e'(kind[i]) == REQ_STORE);
    assign stEv[i] = isSt[i] && evict[i];
  end

  // cand is younger than baseAge under wrapping tags
  function automatic logic isYounger(input logic [AGE_W-1:0] baseAge,
                                     input logic [AGE_W-1:0] cand);
    logic [AGE_W-1:0] diff;
    diff = cand - baseAge;
    return (diff != '0) && !diff[AGE_MSB];
  endfunction

  assign addrMatch = (addr[0] == addr[1]);
  assign bothValid = &valid;

  always_comb begin
    pairLegal = 1'b1;
    if (isLd[0] && isLd[1])
      pairLegal = 1'b1;
    else if (isSt[0] && isSt[1])
      pairLegal = !addrMatch && !(stEv[0] && stEv[1]);
    else if (isLd[0] && isSt[1])
      pairLegal = isYounger(age[0], age[1]);
    else if (isSt[0] && isLd[1])
      pairLegal = isYounger(age[1], age[0]);
  end

  assign grant[0]  = !strobes.holdAll && valid[0];
  assign grant[1]  = !strobes.holdAll && valid[1] && (!valid[0] || pairLegal);
  assign stallLate = !strobes.holdAll && bothValid && !pairLegal;

  // R6: a stalled pair issues only the front slot
  a_r6_illegal_front: assert property (@(posedge clk) disable iff (!rstN)
    stallLate |-> (grant[0] && !grant[1]));
  // R9: nothing issues or stalls during a miss hold
  a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdAll |-> (grant == '0 && !stallLate));
  // R2: two loads always pair
  a_r2_loads_pair: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.holdAll && isLd[0] && isLd[1]) |-> (grant == 2'b11));
  // R7: a lone request issues without a stall
  a_r7_lone_grant: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.holdAll && $countones(valid) == 1) |-> (grant == valid && !stallLate));
  // R10: grants only for valid slots
  a_r10_grant_valid: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~valid) == '0);

endmodule

// File: rtl/mem_pair_arbiter.sv
module mem_pair_arbiter
  import mpa_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AGE_W  = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              s0Valid,
  input  logic              s0Store,
  input  logic              s0Evict,
  input  logic [ADDR_W-1:0] s0Addr,
  input  logic [AGE_W-1:0]  s0Age,
  input  logic              s1Valid,
  input  logic              s1Store,
  input  logic              s1Evict,
  input  logic [ADDR_W-1:0] s1Addr,
  input  logic [AGE_W-1:0]  s1Age,
  input  logic              missStart,
  input  logic              fillDone,
  output logic              grant0,
  output logic              grant1,
  output logic              stall1,
  output logic              missStall
);

  ctrlStrobes_t         strobes;
  logic [NUM_SLOTS-1:0] grantVec;

  mpa_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .missStart (missStart),
    .fillDone  (fillDone),
    .strobes   (strobes),
    .missStall (missStall)
  );

  mpa_datapath #(.ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .valid     ({s1Valid, s0Valid}),
    .kind      ({s1Store, s0Store}),
    .evict     ({s1Evict, s0Evict}),
    .addr      ({s1Addr, s0Addr}),
    .age       ({s1Age, s0Age}),
    .grant     (grantVec),
    .stallLate (stall1)
  );

  assign grant0 = grantVec[0];
  assign grant1 = grantVec[1];

endmodule

// File: tb/sim_mem_pair_arbiter.sv
module sim_mem_pair_arbiter;

  localparam int P = 10;

  typedef struct packed {
    logic v0; logic st0; logic ev0; logic [11:0] a0; logic [2:0] t0;
    logic v1; logic st1; logic ev1; logic [11:0] a1; logic [2:0] t1;
    logic [2:0] exp;   // {grant0, grant1, stall1}
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,12'h010,3'd0, 1'b1,1'b0,1'b0,12'h020,3'd1, 3'b110}, // R2 loads
    '{1'b1,1'b0,1'b1,12'h055,3'd0, 1'b1,1'b0,1'b1,12'h055,3'd1, 3'b110}, // R2 same addr+evict
    '{1'b1,1'b1,1'b0,12'h100,3'd0, 1'b1,1'b1,1'b0,12'h101,3'd1, 3'b110}, // R3 diff addr
    '{1'b1,1'b1,1'b0,12'h7ff,3'd0, 1'b1,1'b1,1'b0,12'h7ff,3'd1, 3'b101}, // R3 same addr
    '{1'b1,1'b1,1'b1,12'h200,3'd0, 1'b1,1'b1,1'b1,12'h300,3'd1, 3'b101}, // R5 two evicts
    '{1'b1,1'b1,1'b1,12'h200,3'd0, 1'b1,1'b1,1'b0,12'h300,3'd1, 3'b110}, // R5 one evict
    '{1'b1,1'b0,1'b0,12'h123,3'd2, 1'b1,1'b1,1'b0,12'h123,3'd3, 3'b110}, // R4 store younger
    '{1'b1,1'b1,1'b0,12'h040,3'd3, 1'b1,1'b0,1'b0,12'h041,3'd4, 3'b101}, // R4 store older
    '{1'b1,1'b0,1'b0,12'h001,3'd7, 1'b1,1'b1,1'b0,12'h002,3'd0, 3'b110}, // R4 wrap legal
    '{1'b1,1'b0,1'b0,12'h001,3'd0, 1'b1,1'b1,1'b0,12'h002,3'd0, 3'b101}, // R4 equal tags
    '{1'b1,1'b0,1'b0,12'h001,3'd0, 1'b1,1'b1,1'b0,12'h002,3'd4, 3'b101}, // R4 half range
    '{1'b1,1'b1,1'b0,12'h0aa,3'd5, 1'b1,1'b0,1'b0,12'h0bb,3'd4, 3'b110}, // R4 store in slot0 younger
    '{1'b0,1'b1,1'b1,12'h000,3'd0, 1'b1,1'b1,1'b1,12'h000,3'd1, 3'b010}, // R7 lone slot1
    '{1'b1,1'b1,1'b1,12'h3c3,3'd6, 1'b0,1'b0,1'b0,12'h000,3'd0, 3'b100}, // R7 lone slot0
    '{1'b0,1'b0,1'b0,12'h000,3'd0, 1'b0,1'b0,1'b0,12'h000,3'd0, 3'b000}  // R10 none
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic s0Valid = 0, s0Store = 0, s0Evict = 0, s1Valid = 0, s1Store = 0, s1Evict = 0;
  logic [11:0] s0Addr = '0, s1Addr = '0;
  logic [2:0] s0Age = '0, s1Age = '0;
  logic missStart = 0, fillDone = 0;
  logic grant0, grant1, stall1, missStall;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(P/2) clk = ~clk;

  mem_pair_arbiter u0 (.*);

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual {g0,g1,st1,ms}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {grant0, grant1, stall1, missStall};
  endfunction

  task automatic apply(vec_t v);
    s0Valid = v.v0; s0Store = v.st0; s0Evict = v.ev0; s0Addr = v.a0; s0Age = v.t0;
    s1Valid = v.v1; s1Store = v.st1; s1Evict = v.ev1; s1Addr = v.a1; s1Age = v.t1;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(P*5000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    apply(VECS[0]);
    #(P/4) check("R1 reset state", outs(), 4'b1100);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) apply(VECS[i]);
      #(P/4) check($sformatf("vector %0d (R2-R7,R10)", i), outs(), {VECS[i].exp, 1'b0});
    end

    // R8: fill pulse while idle has no effect
    @(negedge clk) apply(VECS[0]); fillDone = 1;
    @(negedge clk) fillDone = 0;
    #(P/4) check("R8 idle fill ignored", outs(), 4'b1100);

    // R8/R9: miss start, grants continue in the start cycle itself
    @(negedge clk) missStart = 1;
    #(P/4) check("R8 start cycle still grants", outs(), 4'b1100);
    @(negedge clk) missStart = 0; apply(VECS[3]);   // illegal pair during hold
    #(P/4) check("R9 hold hides illegal pair", outs(), 4'b0001);
    @(negedge clk) missStart = 1;                   // repeated start ignored
    @(negedge clk) missStart = 0; apply(VECS[12]);
    #(P/4) check("R9 hold blocks lone request", outs(), 4'b0001);
    repeat (3) @(negedge clk);
    #(P/4) check("R8 hold persists", outs(), 4'b0001);
    @(negedge clk) fillDone = 1;
    #(P/4) check("R8 still held in fill cycle", outs(), 4'b0001);
    @(negedge clk) fillDone = 0;
    #(P/4) check("R8 released after fill", outs(), 4'b0100);
    @(negedge clk) apply(VECS[4]);
    #(P/4) check("R6 illegal after release", outs(), 4'b1010);

    // R1: reset during a hold clears it
    @(negedge clk) missStart = 1;
    @(negedge clk) missStart = 0; rstN = 0;
    @(negedge clk) rstN = 1; apply(VECS[0]);
    #(P/4) check("R1 reset clears hold", outs(), 4'b1100);

    finish();
  end

endmodule